// File: doc/BRIEF.md
# Condition Code Flag and Branch Test Unit

This block keeps the five condition flags of a 32-bit processor datapath and computes the sized result of the simple integer operations that set them. Each cycle it takes an operation class, an operand size, a source and a destination operand, and forms the result at byte, word or long width. When the write-enable is high, it loads the flag subset owned by that class into its flag register on the next clock edge.

A second, purely combinational path decodes a 4-bit condition selector against the registered flags and raises a single condition-true signal. A branch, set-on-condition or loop-decrement stage uses it in the same cycle. Because the test always reads the registered flags, an instruction that writes flags and an instruction that tests them can share a cycle: the test sees the flags from before that cycle's update.

Top module: `ccr_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, all five flags read 0.
- R2: The flags output packs C in bit 0, V in bit 1, Z in bit 2, N in bit 3 and X in bit 4. It changes only on a rising clock edge with `wr_en` high and holds its value in every other cycle.
- R3: `op_size` selects 0 = byte, 1 = word, 2 or 3 = long. `result` is zero above the selected width, and operand bits above that width have no effect. `op_cls` selects 0 = add (dst+src), 1 = subtract (dst-src), 2 = compare (result is the sized destination), 3 = move (sized source), 4 = AND, 5 = OR, 6 = EOR, 7 = behaves as move.
- R4: Add loads C and X with the carry out of the sized MSB. It sets V when both sized operands have the same sign and the sum's sign differs from it.
- R5: Subtract loads C and X with the borrow, which is set when the sized source is greater than the sized destination (unsigned). It sets V when the operand signs differ and the difference's sign differs from the destination's sign.
- R6: Compare loads C, V, N and Z exactly as subtract would, and leaves X unchanged.
- R7: Z is set when the sized value the flags are taken from is zero. That value is the difference for compare and the result for every other class. N copies bit 7, 15 or 31 of the same value.
- R8: Move, AND, OR and EOR clear C and V, set N and Z from the result, and leave X unchanged.
- R9: `cond_true` follows the registered flags for codes 0 = always, 1 = never, 2 = !C&!Z, 3 = C|Z, 4 = !C, 5 = C, 6 = !Z, 7 = Z, 8 = !V, 9 = V, 10 = !N and 11 = N.
- R10: `cond_true` follows the signed codes 12 = (N==V), 13 = (N!=V), 14 = !Z&(N==V) and 15 = Z|(N!=V).
- R11: In a cycle where `wr_en` is high, `cond_true` reflects the flags from before that cycle's update. The new flags take effect only after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_cls | input | 3 | Operation class |
| op_size | input | 2 | Operand size |
| src | input | 32 | Source operand |
| dst | input | 32 | Destination operand |
| wr_en | input | 1 | Flag write-enable |
| cond_sel | input | 4 | Condition code to test |
| result | output | 32 | Sized result |
| flags | output | 5 | Registered flags {X,N,Z,V,C} |
| cond_true | output | 1 | Selected condition holds |

## Verification
The flag update and the condition test can fall in the same cycle. The bench provokes this on every operation it drives: while `wr_en` and a new operation are applied, it moves `cond_sel` through a rotating code and samples `cond_true` before the clock edge. It judges that value against the condition computed from the flags the bench model held before the operation. After the edge it checks the new flags, then sweeps all sixteen codes against them.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [2:0] {
    CLS_ADD  = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_CMP  = 3'd2,
    CLS_MOVE = 3'd3,
    CLS_AND  = 3'd4,
    CLS_OR   = 3'd5,
    CLS_EOR  = 3'd6,
    CLS_RSV  = 3'd7
  } op_cls_t;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_L = 2'd2,
    SZ_X = 2'd3
  } op_size_t;

  localparam int FLAG_W = 5;
  localparam int FB_C   = 0;
  localparam int FB_V   = 1;
  localparam int FB_Z   = 2;
  localparam int FB_N   = 3;
  localparam int FB_X   = 4;
endpackage

// File: rtl/ccr_alu.sv
module ccr_alu
  import ccr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_cls_t           cls,
  input  op_size_t          sz,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  output logic [DATA_W-1:0] res,
  output logic              carry,
  output logic              ovf,
  output logic              neg,
  output logic              zero
);
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  logic [DATA_W-1:0] mask, a_m, b_m, raw, dif_m;
  logic [DATA_W:0]   sum_w, dif_w;
  logic sa, sb, ssum, sdif, sraw, cadd, bsub;
  logic arith_sub;

  always_comb begin
    mask = '1;
    unique case (sz)
      SZ_B:    mask = DATA_W'({BYTE_W{1'b1}});
      SZ_W:    mask = DATA_W'({WORD_W{1'b1}});
      default: mask = '1;
    endcase
    a_m   = dst & mask;
    b_m   = src & mask;
    sum_w = {1'b0, a_m} + {1'b0, b_m};
    dif_w = {1'b0, a_m} - {1'b0, b_m};
    dif_m = dif_w[DATA_W-1:0] & mask;

    unique case (cls)
      CLS_ADD: raw = sum_w[DATA_W-1:0];
      CLS_SUB: raw = dif_w[DATA_W-1:0];
      CLS_CMP: raw = a_m;
      CLS_AND: raw = a_m & b_m;
      CLS_OR:  raw = a_m | b_m;
      CLS_EOR: raw = a_m ^ b_m;
      default: raw = b_m;
    endcase
    res = raw & mask;

    unique case (sz)
      SZ_B: begin
        sa = dst[BYTE_W-1];  sb = src[BYTE_W-1];
        ssum = sum_w[BYTE_W-1]; sdif = dif_w[BYTE_W-1];
        sraw = raw[BYTE_W-1];
        cadd = sum_w[BYTE_W]; bsub = dif_w[BYTE_W];
      end
      SZ_W: begin
        sa = dst[WORD_W-1];  sb = src[WORD_W-1];
        ssum = sum_w[WORD_W-1]; sdif = dif_w[WORD_W-1];
        sraw = raw[WORD_W-1];
        cadd = sum_w[WORD_W]; bsub = dif_w[WORD_W];
      end
      default: begin
        sa = dst[DATA_W-1];  sb = src[DATA_W-1];
        ssum = sum_w[DATA_W-1]; sdif = dif_w[DATA_W-1];
        sraw = raw[DATA_W-1];
        cadd = sum_w[DATA_W]; bsub = dif_w[DATA_W];
      end
    endcase

    arith_sub = (cls == CLS_SUB) || (cls == CLS_CMP);
    if (cls == CLS_ADD) begin
      carry = cadd;
      ovf   = (sa == sb) && (ssum != sa);
    end else if (arith_sub) begin
      carry = bsub;
      ovf   = (sa != sb) && (sdif != sa);
    end else begin
      carry = 1'b0;
      ovf   = 1'b0;
    end

    if (cls == CLS_CMP) begin
      neg  = sdif;
      zero = (dif_m == '0);
    end else begin
      neg  = sraw;
      zero = (res == '0);
    end
  end
endmodule

// File: rtl/ccr_flag_next.sv
module ccr_flag_next
  import ccr_pkg::*;
(
  input  op_cls_t           cls,
  input  logic [FLAG_W-1:0] cur,
  input  logic              carry,
  input  logic              ovf,
  input  logic              neg,
  input  logic              zero,
  output logic [FLAG_W-1:0] nxt
);
  always_comb begin
    nxt       = '0;
    nxt[FB_C] = carry;
    nxt[FB_V] = ovf;
    nxt[FB_Z] = zero;
    nxt[FB_N] = neg;
    if ((cls == CLS_ADD) || (cls == CLS_SUB))
      nxt[FB_X] = carry;
    else
      nxt[FB_X] = cur[FB_X];
  end
endmodule

// File: rtl/ccr_cond.sv
module ccr_cond
  import ccr_pkg::*;
(
  input  logic [FLAG_W-1:0] fl,
  input  logic [3:0]        sel,
  output logic              hit
);
  logic c, v, z, n, sgn_ok;

  always_comb begin
    c = fl[FB_C];
    v = fl[FB_V];
    z = fl[FB_Z];
    n = fl[FB_N];
    sgn_ok = (n == v);
    unique case (sel)
      4'd0:  hit = 1'b1;
      4'd1:  hit = 1'b0;
      4'd2:  hit = !c && !z;
      4'd3:  hit = c || z;
      4'd4:  hit = !c;
      4'd5:  hit = c;
      4'd6:  hit = !z;
      4'd7:  hit = z;
      4'd8:  hit = !v;
      4'd9:  hit = v;
      4'd10: hit = !n;
      4'd11: hit = n;
      4'd12: hit = sgn_ok;
      4'd13: hit = !sgn_ok;
      4'd14: hit = !z && sgn_ok;
      default: hit = z || !sgn_ok;
    endcase
  end
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_cls,
  input  logic [1:0]        op_size,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic              wr_en,
  input  logic [3:0]        cond_sel,
  output logic [DATA_W-1:0] result,
  output logic [4:0]        flags,
  output logic              cond_true
);
  localparam int BYTE_W = 8;

  op_cls_t           cls;
  op_size_t          sz;
  logic              carry, ovf, neg, zero;
  logic [FLAG_W-1:0] flags_q, flags_d, flags_nx;

  assign cls = op_cls_t'(op_cls);
  assign sz  = op_size_t'(op_size);

  ccr_alu #(.DATA_W(DATA_W)) i_alu (
    .cls(cls), .sz(sz), .src(src), .dst(dst),
    .res(result), .carry(carry), .ovf(ovf), .neg(neg), .zero(zero)
  );

  ccr_flag_next i_next (
    .cls(cls), .cur(flags_q), .carry(carry), .ovf(ovf),
    .neg(neg), .zero(zero), .nxt(flags_nx)
  );

  always_comb begin
    flags_d = flags_q;
    if (wr_en)
      flags_d = flags_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_q <= '0;
    else
      flags_q <= flags_d;
  end

  ccr_cond i_cond (.fl(flags_q), .sel(cond_sel), .hit(cond_true));

  assign flags = flags_q;

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(flags));

  // R6 R8
  x_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(op_cls inside {3'd0, 3'd1})) |=> flags[FB_X] == $past(flags[FB_X]));

  // R8
  logic_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (op_cls inside {3'd3, 3'd4, 3'd5, 3'd6, 3'd7})) |=> flags[FB_V:FB_C] == 2'b00);

  // R7
  z_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_cls != 3'd2) |=> flags[FB_Z] == ($past(result) == '0));

  // R4
  add_xc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_cls == 3'd0) |=> flags[FB_X] == flags[FB_C]);

  // R3
  byte_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_size == 2'd0) |-> result[DATA_W-1:BYTE_W] == '0);
endmodule

// File: tb/test_ccr_unit.sv
module test_ccr_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_cls = '0;
  logic [1:0]  op_size = '0;
  logic [31:0] src = '0, dst = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  cond_sel = '0;
  logic [31:0] result;
  logic [4:0]  flags;
  logic        cond_true;

  int n_chk = 0;
  int n_err = 0;
  logic [4:0] mflags = '0;
  int rot = 0;

  always #(CLK_P/2) clk = ~clk;

  ccr_unit i_ccr_unit (
    .clk(clk), .rst_n(rst_n), .op_cls(op_cls), .op_size(op_size),
    .src(src), .dst(dst), .wr_en(wr_en), .cond_sel(cond_sel),
    .result(result), .flags(flags), .cond_true(cond_true)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit cmodel(input logic [4:0] f, input int sel);
    bit c, v, z, n;
    c = f[0]; v = f[1]; z = f[2]; n = f[3];
    case (sel)
      0: return 1'b1;
      1: return 1'b0;
      2: return !c && !z;
      3: return c || z;
      4: return !c;
      5: return c;
      6: return !z;
      7: return z;
      8: return !v;
      9: return v;
      10: return !n;
      11: return n;
      12: return n == v;
      13: return n != v;
      14: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  task automatic do_op(input int cls, input int sz, input logic [31:0] s, input logic [31:0] d);
    longint unsigned w, m, a, b, r, fv;
    logic [4:0] ef;
    bit c, v, x;
    string rq;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    m = (64'd1 << w) - 1;
    a = d & m; b = s & m;
    c = 0; v = 0; x = mflags[4];
    case (cls)
      0: begin r = (a + b) & m; c = ((a + b) >> w) & 1;
               v = (((~(a ^ b)) & (a ^ r)) >> (w - 1)) & 1; x = c; fv = r; rq = "R4"; end
      1: begin r = (a - b) & m; c = b > a;
               v = (((a ^ b) & (a ^ r)) >> (w - 1)) & 1; x = c; fv = r; rq = "R5"; end
      2: begin fv = (a - b) & m; r = a; c = b > a;
               v = (((a ^ b) & (a ^ fv)) >> (w - 1)) & 1; rq = "R6"; end
      4: begin r = a & b; fv = r; rq = "R8"; end
      5: begin r = a | b; fv = r; rq = "R8"; end
      6: begin r = a ^ b; fv = r; rq = "R8"; end
      default: begin r = b; fv = r; rq = "R8"; end
    endcase
    ef = {x, 1'((fv >> (w - 1)) & 1), fv == 0, v, c};
    @(negedge clk);
    op_cls = 3'(cls); op_size = 2'(sz); src = s; dst = d; wr_en = 1'b1;
    cond_sel = 4'(rot); rot = (rot + 1) % 16;
    #1;
    check(result == r[31:0], "R3", result, r);
    check(cond_true == cmodel(mflags, int'(cond_sel)), "R11", cond_true, cmodel(mflags, int'(cond_sel)));
    @(negedge clk);
    wr_en = 1'b0;
    check(flags == ef, rq, flags, ef);
    check(flags[2] == ef[2] && flags[3] == ef[3], "R7", flags, ef);
    mflags = ef;
    for (int k = 0; k < 16; k++) begin
      cond_sel = 4'(k);
      #1;
      check(cond_true == cmodel(mflags, k), (k < 12) ? "R9" : "R10", cond_true, cmodel(mflags, k));
    end
  endtask

  function automatic logic [31:0] pat(input int sz, input int k);
    logic [31:0] m, hi, top;
    m   = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    top = (sz == 0) ? 32'h80 : (sz == 1) ? 32'h8000 : 32'h8000_0000;
    hi  = 32'hDEAD_BEEF & ~m;
    case (k)
      0: return hi;
      1: return hi | 32'd1;
      2: return hi | (top - 1);
      3: return hi | top;
      4: return hi | m;
      5: return hi | (32'h5A5A_A5A5 & m);
      6: return hi | (m - 1);
      default: return hi | (top + 1);
    endcase
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 1);
    check(flags == 5'd0, "R1", flags, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(flags == 5'd0, "R1", flags, 0);
    cond_sel = 4'd0; #1;
    check(cond_true == 1'b1, "R9", cond_true, 1);
    cond_sel = 4'd7; #1;
    check(cond_true == 1'b0, "R9", cond_true, 0);

    // R2: operation applied with wr_en low leaves flags untouched
    op_cls = 3'd1; op_size = 2'd0; src = 32'd1; dst = 32'd0; wr_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check(flags == 5'd0, "R2", flags, 0);

    // byte: near-exhaustive grid, all classes
    for (int cl = 0; cl < 8; cl++)
      for (int i = 0; i < 18; i++)
        for (int j = 0; j < 18; j++)
          do_op(cl, 0, 32'(i * 15) | 32'hABCD_0000, 32'(j * 15) | 32'h1234_5600);

    // word and long (size codes 1, 2, 3): corner patterns with junk upper bits
    for (int sz = 1; sz < 4; sz++)
      for (int cl = 0; cl < 8; cl++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            do_op(cl, sz, pat(sz, i), pat(sz, j));

    // R2: hold after nonzero flags
    do_op(1, 0, 32'd1, 32'd0);
    op_cls = 3'd3; src = 32'd0; wr_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check(flags == mflags, "R2", flags, mflags);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule